// File: doc/BRIEF.md
# Byte/Word Shift and Rotate Unit with Flag Generation

This block shifts or rotates an 8-bit or 16-bit operand by a count and produces the result together with the carry, overflow, sign, zero and parity flags. It serves an integer execution pipe. A three-bit operation code picks one of these operations: logical left shift, logical right shift, arithmetic right shift, plain rotates in either direction, and rotates that pass through the carry flag.

The caller supplies the current flag values along with the operand. Any flag that the operation does not define is returned as it came in. Only the low five bits of the 8-bit count are used. A masked count of zero leaves the operand and every flag as they were.

The unit computes in a single cycle using barrel logic. A `go` strobe loads the result registers, and `done` pulses in the cycle after. The outputs then hold until the next `go`.

Top module: `shrot_unit`

## Requirements
- R1: `done` is 1 in the cycle after a cycle in which `go` was 1, and 0 otherwise. The result and flag outputs change only on a `go` cycle and hold their values between operations.
- R2: The count is reduced to `count[4:0]`, so `count[7:5]` has no effect. When the reduced count is 0, `result` equals the operand and `cf`, `of`, `sf`, `zf` and `pf` equal `cf_in`, `of_in`, `sf_in`, `zf_in` and `pf_in`.
- R3: Opcode 100 and opcode 110 both shift left, and opcode 101 shifts right. Both directions fill with zeros. `cf` receives the last bit shifted out, and it is 0 once the count exceeds the operand width.
- R4: Opcode 111 shifts right and fills from the left with copies of the original sign bit. For example, byte 0xFB shifted by 1 gives 0xFD.
- R5: Opcode 000 rotates left and opcode 001 rotates right. `cf` receives the last bit rotated out. `sf`, `zf` and `pf` equal their incoming values.
- R6: Opcode 010 rotates left and opcode 011 rotates right through the carry. The carry acts as one extra bit above the operand, giving a 9-bit or 17-bit rotation. `sf`, `zf` and `pf` equal their incoming values.
- R7: With a reduced count of exactly 1, `of` is 1 when the top bit of the result differs from the top bit of the operand, and 0 otherwise. With a reduced count of 2 or more, `of` equals `of_in`.
- R8: After a shift (opcodes 1xx) with a nonzero reduced count: `sf` is the top bit of the result, `zf` is 1 when the result is zero, and `pf` is 1 when `result[7:0]` holds an even number of ones.
- R9: With `word` at 0, the unit works on `operand[7:0]`. `operand[15:8]` is ignored, and `result[15:8]` is 0.
- R10: During reset, `done`, `result` and all flag outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go | input | 1 | Start strobe; the operation is captured at this edge |
| op | input | 3 | Operation code |
| word | input | 1 | 1 selects a 16-bit operand, 0 selects an 8-bit operand |
| operand | input | 16 | Value to shift or rotate |
| count | input | 8 | Shift count; only bits 4:0 are used |
| cf_in | input | 1 | Incoming carry flag |
| of_in | input | 1 | Incoming overflow flag |
| sf_in | input | 1 | Incoming sign flag |
| zf_in | input | 1 | Incoming zero flag |
| pf_in | input | 1 | Incoming parity flag |
| done | output | 1 | One-cycle pulse when results are valid |
| result | output | 16 | Shifted or rotated value |
| cf | output | 1 | Carry flag out |
| of | output | 1 | Overflow flag out |
| sf | output | 1 | Sign flag out |
| zf | output | 1 | Zero flag out |
| pf | output | 1 | Parity flag out |

## Verification
The hardest cases to reach are the counts at which the reduced count wraps around the 9-bit or 17-bit carry ring. These appear only for particular raw counts, such as 9, 18 and 27 in byte mode, or 17 in word mode. Counts that differ only in bits 7:5 must give identical results.

The stimulus sweeps every raw count from 0 to 255 for each opcode in both widths. It uses several operand patterns and varied incoming carry and flags, so every wrap point and every masked alias is applied with carry both set and clear.

// File: rtl/shrot_pkg.sv
package shrot_pkg;
   typedef enum logic [2:0] {
      SR_ROL = 3'b000,
      SR_ROR = 3'b001,
      SR_RCL = 3'b010,
      SR_RCR = 3'b011,
      SR_SHL = 3'b100,
      SR_SHR = 3'b101,
      SR_SAL = 3'b110,
      SR_SAR = 3'b111
   } sr_op_e;

   function automatic logic even_par8(input logic [7:0] v);
      return ~(^v);
   endfunction
endpackage

// File: rtl/shrot_cnt.sv
module shrot_cnt #(
   parameter int CNT_W  = 8,
   parameter int USE_W  = 5
) (
   input  logic [CNT_W-1:0] count,
   output logic [USE_W-1:0] amt,
   output logic             amt_zero,
   output logic             amt_one
);
   initial begin
      if (USE_W > CNT_W) $error("shrot_cnt: USE_W exceeds CNT_W");
   end

   assign amt      = count[USE_W-1:0];
   assign amt_zero = (amt == '0);
   assign amt_one  = (amt == USE_W'(1));
endmodule

// File: rtl/shrot_lane.sv
module shrot_lane
   import shrot_pkg::*;
#(
   parameter int LW    = 8,
   parameter int USE_W = 5
) (
   input  sr_op_e           op,
   input  logic [LW-1:0]    opnd,
   input  logic [USE_W-1:0] amt,
   input  logic             cin,
   output logic [LW-1:0]    res,
   output logic             cout
);
   localparam int SPAN = 1 << USE_W;
   localparam int RW   = LW + 1;

   initial begin
      if (LW < 8) $error("shrot_lane: lane narrower than parity window");
   end

   logic [USE_W-1:0]        rot_n, rcy_n;
   logic [LW+SPAN-1:0]      t_left;
   logic [LW+SPAN-1:0]      t_right;
   logic signed [LW+SPAN-1:0] t_arith;
   logic [2*LW-1:0]         t_rol, t_ror;
   logic [RW-1:0]           ring;
   logic [2*RW-1:0]         t_rcl, t_rcr;
   logic [RW-1:0]           ring_l, ring_r;

   assign rot_n = USE_W'(32'(amt) % LW);
   assign rcy_n = USE_W'(32'(amt) % RW);

   assign t_left  = {{SPAN{1'b0}}, opnd} << amt;
   assign t_right = {opnd, {SPAN{1'b0}}} >> amt;
   assign t_arith = $signed({opnd, {SPAN{1'b0}}}) >>> amt;

   assign t_rol = {opnd, opnd} << rot_n;
   assign t_ror = {opnd, opnd} >> rot_n;

   assign ring   = {cin, opnd};
   assign t_rcl  = {ring, ring} << rcy_n;
   assign t_rcr  = {ring, ring} >> rcy_n;
   assign ring_l = t_rcl[2*RW-1:RW];
   assign ring_r = t_rcr[RW-1:0];

   always_comb begin
      res  = opnd;
      cout = cin;
      unique case (op)
         SR_SHL, SR_SAL: begin
            res  = t_left[LW-1:0];
            cout = t_left[LW];
         end
         SR_SHR: begin
            res  = t_right[LW+SPAN-1:SPAN];
            cout = t_right[SPAN-1];
         end
         SR_SAR: begin
            res  = t_arith[LW+SPAN-1:SPAN];
            cout = t_arith[SPAN-1];
         end
         SR_ROL: begin
            res  = t_rol[2*LW-1:LW];
            cout = t_rol[LW];
         end
         SR_ROR: begin
            res  = t_ror[LW-1:0];
            cout = t_ror[LW-1];
         end
         SR_RCL: begin
            res  = ring_l[LW-1:0];
            cout = ring_l[LW];
         end
         SR_RCR: begin
            res  = ring_r[LW-1:0];
            cout = ring_r[LW];
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
   import shrot_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int WORD_W = 16,
   parameter int CNT_W  = 8,
   parameter int USE_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic [2:0]        op,
   input  logic              word,
   input  logic [WORD_W-1:0] operand,
   input  logic [CNT_W-1:0]  count,
   input  logic              cf_in,
   input  logic              of_in,
   input  logic              sf_in,
   input  logic              zf_in,
   input  logic              pf_in,
   output logic              done,
   output logic [WORD_W-1:0] result,
   output logic              cf,
   output logic              of,
   output logic              sf,
   output logic              zf,
   output logic              pf
);
   localparam int NLANE = 2;

   initial begin
      if (WORD_W <= BYTE_W) $error("shrot_unit: WORD_W must exceed BYTE_W");
      if (BYTE_W < 8)       $error("shrot_unit: BYTE_W below 8");
   end

   sr_op_e           op_e;
   logic [USE_W-1:0] amt;
   logic             amt_zero, amt_one;

   assign op_e = sr_op_e'(op);

   shrot_cnt #(.CNT_W(CNT_W), .USE_W(USE_W)) u_cnt (
      .count    (count),
      .amt      (amt),
      .amt_zero (amt_zero),
      .amt_one  (amt_one)
   );

   logic [WORD_W-1:0] lane_res [NLANE];
   logic              lane_cy  [NLANE];
   logic              lane_msb_in  [NLANE];
   logic              lane_msb_out [NLANE];

   for (genvar g = 0; g < NLANE; g++) begin : g_lane
      localparam int LW = (g == 0) ? BYTE_W : WORD_W;
      logic [LW-1:0] r;
      logic          c;
      shrot_lane #(.LW(LW), .USE_W(USE_W)) u_lane (
         .op   (op_e),
         .opnd (operand[LW-1:0]),
         .amt  (amt),
         .cin  (cf_in),
         .res  (r),
         .cout (c)
      );
      always_comb begin
         lane_res[g] = '0;
         lane_res[g][LW-1:0] = r;
      end
      assign lane_cy[g]      = c;
      assign lane_msb_in[g]  = operand[LW-1];
      assign lane_msb_out[g] = r[LW-1];
   end

   logic              sel;
   logic [WORD_W-1:0] n_res;
   logic              n_cf, n_of, n_sf, n_zf, n_pf, is_shift;

   assign sel      = word;
   assign is_shift = op[2];

   always_comb begin
      if (amt_zero) begin
         n_res = sel ? operand : {{(WORD_W-BYTE_W){1'b0}}, operand[BYTE_W-1:0]};
         n_cf = cf_in; n_of = of_in; n_sf = sf_in; n_zf = zf_in; n_pf = pf_in;
      end else begin
         n_res = lane_res[sel];
         n_cf  = lane_cy[sel];
         n_of  = amt_one ? (lane_msb_in[sel] ^ lane_msb_out[sel]) : of_in;
         if (is_shift) begin
            n_sf = lane_msb_out[sel];
            n_zf = (n_res == '0);
            n_pf = even_par8(n_res[7:0]);
         end else begin
            n_sf = sf_in; n_zf = zf_in; n_pf = pf_in;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done   <= 1'b0;
         result <= '0;
         {cf, of, sf, zf, pf} <= '0;
      end else begin
         done <= go;
         if (go) begin
            result <= n_res;
            cf <= n_cf; of <= n_of; sf <= n_sf; zf <= n_zf; pf <= n_pf;
         end
      end
   end

   p_done_follows_go_r1: assert property (@(posedge clk) disable iff (!rst_n)
      go |=> done);
   p_hold_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !go |=> $stable(result) && $stable(cf) && $stable(of));
   p_zero_count_passthru_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (go && word && count[USE_W-1:0] == '0) |=>
      (result == $past(operand) && cf == $past(cf_in) && of == $past(of_in)
       && sf == $past(sf_in) && zf == $past(zf_in) && pf == $past(pf_in)));
   p_rotate_keeps_szp_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (go && !op[2]) |=>
      (sf == $past(sf_in) && zf == $past(zf_in) && pf == $past(pf_in)));
   p_single_of_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (go && word && op == 3'b000 && count[USE_W-1:0] == USE_W'(1)) |=>
      (of == ($past(operand[WORD_W-1]) ^ $past(operand[WORD_W-2]))));
   p_byte_high_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (go && !word) |=> (result[WORD_W-1:BYTE_W] == '0));
   p_reset_clear_r10: assert property (@(posedge clk)
      !rst_n |-> (!done && result == '0));
endmodule

// File: tb/shrot_unit_test.sv
module shrot_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        go = 1'b0;
   logic [2:0]  op = '0;
   logic        word = 1'b0;
   logic [15:0] operand = '0;
   logic [7:0]  count = '0;
   logic        cf_in = 1'b0, of_in = 1'b0, sf_in = 1'b0, zf_in = 1'b0, pf_in = 1'b0;
   logic        done;
   logic [15:0] result;
   logic        cf, of, sf, zf, pf;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   shrot_unit uut (
      .clk(clk), .rst_n(rst_n), .go(go), .op(op), .word(word),
      .operand(operand), .count(count),
      .cf_in(cf_in), .of_in(of_in), .sf_in(sf_in), .zf_in(zf_in), .pf_in(pf_in),
      .done(done), .result(result),
      .cf(cf), .of(of), .sf(sf), .zf(zf), .pf(pf)
   );

   task automatic chk(input string req, input string what,
                      input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // reference: step-by-step, one bit per iteration
   logic [15:0] e_res;
   logic        e_cf, e_of, e_sf, e_zf, e_pf;

   task automatic model(input logic [2:0] o, input logic w, input logic [15:0] a,
                        input logic [7:0] k, input logic ci, input logic oi,
                        input logic si, input logic zi, input logic pi);
      int L = w ? 16 : 8;
      int n = int'(k) % 32;
      logic [15:0] r, orig;
      logic c, b;
      r = w ? a : {8'h00, a[7:0]};
      orig = r;
      c = ci;
      for (int i = 0; i < n; i++) begin
         case (o)
            3'b100, 3'b110: begin c = r[L-1]; r = r << 1; end
            3'b101: begin c = r[0]; r = r >> 1; end
            3'b111: begin c = r[0]; b = r[L-1]; r = r >> 1; r[L-1] = b; end
            3'b000: begin c = r[L-1]; r = (r << 1) | {15'b0, c}; end
            3'b001: begin c = r[0]; r = r >> 1; r[L-1] = c; end
            3'b010: begin b = r[L-1]; r = (r << 1) | {15'b0, c}; c = b; end
            default: begin b = r[0]; r = r >> 1; r[L-1] = c; c = b; end
         endcase
         if (!w) r[15:8] = 8'h00;
      end
      e_res = r;
      e_cf  = (n == 0) ? ci : c;
      e_of  = (n == 1) ? (r[L-1] ^ orig[L-1]) : oi;
      if (n != 0 && o[2]) begin
         e_sf = r[L-1];
         e_zf = (r == 16'h0);
         e_pf = ~(^r[7:0]);
      end else begin
         e_sf = si; e_zf = zi; e_pf = pi;
      end
   endtask

   function automatic string tag_of(input logic [2:0] o, input logic [7:0] k);
      if (k[4:0] == 5'd0) return "R2";
      case (o)
         3'b000, 3'b001: return "R5";
         3'b010, 3'b011: return "R6";
         3'b111:         return "R4";
         default:        return "R3";
      endcase
   endfunction

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : stim
      logic [15:0] held;
      // R10: reset state
      @(negedge clk);
      chk("R10", "done", {15'b0, done}, 16'h0);
      chk("R10", "result", result, 16'h0);
      chk("R10", "flags", {11'b0, cf, of, sf, zf, pf}, 16'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // spot case R4: byte 0xFB >> 1 arithmetic = 0xFD
      go = 1'b1; op = 3'b111; word = 1'b0; operand = 16'h77FB; count = 8'd1;
      @(negedge clk);
      go = 1'b0;
      chk("R4", "sar -5", result, 16'h00FD);
      chk("R1", "done", {15'b0, done}, 16'h1);
      @(negedge clk);
      chk("R1", "done low", {15'b0, done}, 16'h0);

      for (int w = 0; w < 2; w++) begin
         for (int o = 0; o < 8; o++) begin
            for (int k = 0; k < 256; k++) begin
               for (int p = 0; p < 4; p++) begin
                  logic [15:0] a;
                  string t;
                  case (p)
                     0: a = 16'h8001 ^ (16'(k) * 16'd257);
                     1: a = (16'(k) * 16'h9E37) ^ 16'h5A5A;
                     2: a = {~8'(k), 8'(k)};
                     default: a = (k[0]) ? 16'h0080 : 16'h4000;
                  endcase
                  go = 1'b1; op = 3'(o); word = w[0]; operand = a; count = 8'(k);
                  cf_in = k[0] ^ p[0]; of_in = p[1]; sf_in = k[1];
                  zf_in = k[2] ^ p[1]; pf_in = ~k[3];
                  model(3'(o), w[0], a, 8'(k), cf_in, of_in, sf_in, zf_in, pf_in);
                  t = tag_of(3'(o), 8'(k));
                  @(negedge clk);
                  chk("R1", "done", {15'b0, done}, 16'h1);
                  chk(w[0] ? t : "R9", "result", result, e_res);
                  chk(t, "cf", {15'b0, cf}, {15'b0, e_cf});
                  chk("R7", "of", {15'b0, of}, {15'b0, e_of});
                  chk(o >= 4 ? "R8" : (o >= 2 ? "R6" : "R5"), "sf/zf/pf",
                      {13'b0, sf, zf, pf}, {13'b0, e_sf, e_zf, e_pf});
               end
            end
         end
      end

      // R1: outputs hold while go is low, despite changing inputs
      go = 1'b0;
      held = result;
      operand = 16'hFFFF; count = 8'd3; op = 3'b100;
      @(negedge clk);
      @(negedge clk);
      chk("R1", "hold", result, held);
      chk("R1", "done idle", {15'b0, done}, 16'h0);

      // R2: upper count bits ignored (count 0xE0 masks to 0)
      go = 1'b1; op = 3'b000; word = 1'b1; operand = 16'h1234; count = 8'hE0;
      cf_in = 1'b1; of_in = 1'b0; sf_in = 1'b1; zf_in = 1'b0; pf_in = 1'b1;
      @(negedge clk);
      go = 1'b0;
      chk("R2", "masked zero result", result, 16'h1234);
      chk("R2", "masked zero flags", {11'b0, cf, of, sf, zf, pf}, 16'b10101);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule